// File: doc/BRIEF.md
# Debug Halt and Exception Trap Controller

This block decides when a processor core has to be held for an external debugger. A small register port gives the debugger a control register with a stall request bit and a hold-in-reset bit, a mode register whose single bit stops the stall from reaching the core, a per-exception trap-enable mask and a sticky trap-reason register.

The core reports each exception as a 4-bit code with a one-cycle valid strobe. If the enable bit for that code is set, the block raises `ignore_exc` in the same cycle, so the core skips its own exception handling. It also records the reason and sets the stall request. When the debugger takes the core out of hold-in-reset, the block emits a one-cycle system reset pulse.

Top module: `debug_halt_ctrl`

## Requirements
- R1: A write to address 0 replaces both control bits at once: bit 0 is the stall request and bit 1 is hold-in-reset. A read of address 0 returns them in the same positions, and `hold_reset` follows bit 1.
- R2: `sys_rst_pulse` is high for exactly one cycle. That cycle is the one after a write to address 0 that changes hold-in-reset from 1 to 0. A write that leaves the bit at 0 gives no pulse.
- R3: While hold-in-reset is 1, exceptions have no effect: `ignore_exc` stays low, the reason register does not change and the stall request does not change.
- R4: `core_stall` equals the stall request bit, except that it is 0 whenever bit 0 of the mode register (address 1) is set.
- R5: Exception codes 0 to 12 each have an enable bit at the same position in the trap-enable register (address 2). `ignore_exc` is high in the cycle where `exc_valid` is high and the enable bit for `exc_code` is set.
- R6: A trapped exception ORs its code's bit into the reason register (address 3, same bit positions), and bits that are already set stay set.
- R7: An exception sets the stall request to 1 from the next cycle if it is trapped. If it is not trapped, the stall request goes to 0 from the next cycle and the reason register does not change.
- R8: Writing address 3 clears each reason bit written as 1. If a bit is set by a trap and cleared by a write in the same cycle, the set wins.
- R9: Addresses 4 to 7 are unmapped. An access to them raises `reg_err` and reads as zero, and a write to them changes no register.
- R10: A write to address 0 and an exception in the same cycle: the written stall bit wins, and the reason is still recorded.
- R11: Codes 13 to 15 are never trapped, whatever the enable register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| reg_err | output | 1 | Access to an unmapped address |
| exc_valid | input | 1 | Exception strobe, one cycle per exception |
| exc_code | input | 4 | Exception code |
| ignore_exc | output | 1 | Core must skip its normal exception handling |
| core_stall | output | 1 | Halt request to the core |
| hold_reset | output | 1 | Core is held in reset |
| sys_rst_pulse | output | 1 | One-cycle system reset on release |

## Verification
The assertions assume that `reg_we` and `exc_valid` are never X after reset and that `exc_valid` is a single-cycle strobe. They also assume that the stall checks are valid only in cycles without a register write, since a write to the control or mode register may legally override the trap's effect on the stall. The bench meets this by driving every input at the falling edge. Each exception is issued on its own, with no write in the same cycle, except in the directed tests that set out to check the write-versus-trap priority.

// File: rtl/debug_halt_pkg.sv
package debug_halt_pkg;
  localparam int EXC_COUNT = 13;
  localparam int CODE_W    = 4;
  localparam int ADR_CTRL  = 0;
  localparam int ADR_MODE  = 1;
  localparam int ADR_TRAP  = 2;
  localparam int ADR_WHY   = 3;

  // one-hot reason bit of a code; all zero for codes without an enable
  function automatic logic [EXC_COUNT-1:0] code_onehot(input logic [CODE_W-1:0] code);
    logic [EXC_COUNT-1:0] v;
    v = '0;
    for (int i = 0; i < EXC_COUNT; i++)
      if (code == CODE_W'(i)) v[i] = 1'b1;
    return v;
  endfunction

  // sticky update: clear first, then set, so a new trap survives an ack
  function automatic logic [EXC_COUNT-1:0] merge_reason(
    input logic [EXC_COUNT-1:0] cur,
    input logic [EXC_COUNT-1:0] set,
    input logic [EXC_COUNT-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wr_mode,
  input  logic wd_stall,
  input  logic wd_hold,
  input  logic wd_off,
  input  logic trap_evt,
  input  logic trap_hit,
  output logic stall_bit,
  output logic hold_bit,
  output logic mode_off,
  output logic rst_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_bit <= 1'b0;
      hold_bit  <= 1'b0;
      mode_off  <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        stall_bit <= wd_stall;
        hold_bit  <= wd_hold;
        rst_pulse <= hold_bit & ~wd_hold;
      end else begin
        rst_pulse <= 1'b0;
        if (trap_evt) stall_bit <= trap_hit;
      end
      if (wr_mode) mode_off <= wd_off;
    end
  end
endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit
  import debug_halt_pkg::*;
#(
  parameter int NUM_EXC = EXC_COUNT,
  parameter int CW      = CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_enable,
  input  logic               wr_reason,
  input  logic [NUM_EXC-1:0] wdata,
  input  logic               exc_valid,
  input  logic [CW-1:0]      exc_code,
  input  logic               hold,
  output logic [NUM_EXC-1:0] trap_en_q,
  output logic [NUM_EXC-1:0] reason_q,
  output logic               trap_evt,
  output logic               trap_hit
);
  logic [NUM_EXC-1:0] code_bit;
  logic [NUM_EXC-1:0] set_bits;
  logic [NUM_EXC-1:0] clr_bits;

  assign code_bit = code_onehot(exc_code);
  assign trap_evt = exc_valid & ~hold;
  assign trap_hit = trap_evt & |(code_bit & trap_en_q);
  assign set_bits = trap_hit ? code_bit : '0;
  assign clr_bits = wr_reason ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_en_q <= '0;
      reason_q  <= '0;
    end else begin
      if (wr_enable) trap_en_q <= wdata;
      reason_q <= merge_reason(reason_q, set_bits, clr_bits);
    end
  end
endmodule

// File: rtl/dbg_reg_read.sv
module dbg_reg_read
  import debug_halt_pkg::*;
#(
  parameter int AW      = 3,
  parameter int DW      = 32,
  parameter int NUM_EXC = EXC_COUNT
) (
  input  logic [AW-1:0]      addr,
  input  logic               access,
  input  logic               stall_bit,
  input  logic               hold_bit,
  input  logic               mode_off,
  input  logic [NUM_EXC-1:0] trap_en_q,
  input  logic [NUM_EXC-1:0] reason_q,
  output logic [DW-1:0]      rdata,
  output logic               err
);
  localparam logic [AW-1:0] A_CTRL = AW'(ADR_CTRL);
  localparam logic [AW-1:0] A_MODE = AW'(ADR_MODE);
  localparam logic [AW-1:0] A_TRAP = AW'(ADR_TRAP);
  localparam logic [AW-1:0] A_WHY  = AW'(ADR_WHY);

  always_comb begin
    rdata = '0;
    err   = 1'b0;
    unique case (addr)
      A_CTRL: rdata = DW'({hold_bit, stall_bit});
      A_MODE: rdata = DW'(mode_off);
      A_TRAP: rdata = DW'(trap_en_q);
      A_WHY:  rdata = DW'(reason_q);
      default: err = access;
    endcase
  end
endmodule

// File: rtl/debug_halt_ctrl.sv
module debug_halt_ctrl
  import debug_halt_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int NUM_EXC = EXC_COUNT,
  parameter int CW      = CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_err,
  input  logic              exc_valid,
  input  logic [CW-1:0]     exc_code,
  output logic              ignore_exc,
  output logic              core_stall,
  output logic              hold_reset,
  output logic              sys_rst_pulse
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADR_MODE);
  localparam logic [ADDR_W-1:0] A_TRAP = ADDR_W'(ADR_TRAP);
  localparam logic [ADDR_W-1:0] A_WHY  = ADDR_W'(ADR_WHY);

  // named internal events, visible to the bound checker
  logic               wr_ctrl, wr_mode, wr_trap, wr_why;
  logic               stall_bit, mode_off, trap_evt, trap_hit;
  logic [NUM_EXC-1:0] trap_en_q, reason_q;

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_mode = reg_we && (reg_addr == A_MODE);
  assign wr_trap = reg_we && (reg_addr == A_TRAP);
  assign wr_why  = reg_we && (reg_addr == A_WHY);

  dbg_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wr_mode   (wr_mode),
    .wd_stall  (reg_wdata[0]),
    .wd_hold   (reg_wdata[1]),
    .wd_off    (reg_wdata[0]),
    .trap_evt  (trap_evt),
    .trap_hit  (trap_hit),
    .stall_bit (stall_bit),
    .hold_bit  (hold_reset),
    .mode_off  (mode_off),
    .rst_pulse (sys_rst_pulse)
  );

  dbg_trap_unit #(.NUM_EXC(NUM_EXC), .CW(CW)) u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_enable (wr_trap),
    .wr_reason (wr_why),
    .wdata     (reg_wdata[NUM_EXC-1:0]),
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .hold      (hold_reset),
    .trap_en_q (trap_en_q),
    .reason_q  (reason_q),
    .trap_evt  (trap_evt),
    .trap_hit  (trap_hit)
  );

  dbg_reg_read #(.AW(ADDR_W), .DW(DATA_W), .NUM_EXC(NUM_EXC)) u_read (
    .addr      (reg_addr),
    .access    (reg_we | reg_re),
    .stall_bit (stall_bit),
    .hold_bit  (hold_reset),
    .mode_off  (mode_off),
    .trap_en_q (trap_en_q),
    .reason_q  (reason_q),
    .rdata     (reg_rdata),
    .err       (reg_err)
  );

  assign ignore_exc = trap_hit;
  assign core_stall = stall_bit & ~mode_off;
endmodule

// File: rtl/debug_halt_ctrl_chk.sv
module debug_halt_ctrl_chk #(
  parameter int NUM_EXC = 13,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic               wr_why,
  input logic               mode_off,
  input logic               exc_valid,
  input logic               ignore_exc,
  input logic               core_stall,
  input logic               hold_reset,
  input logic               sys_rst_pulse,
  input logic               reg_err,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [NUM_EXC-1:0] reason_q
);
  assert_pulse_on_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> ($past(hold_reset) && !hold_reset));
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> !sys_rst_pulse);
  assert_quiet_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_reset |-> !ignore_exc);
  assert_mask_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off |-> !core_stall);
  assert_reason_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_why) |-> (($past(reason_q) & ~reason_q) == '0));
  assert_trap_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ignore_exc && !reg_we && !mode_off) |=> core_stall);
  assert_miss_unstalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !hold_reset && !ignore_exc && !reg_we) |=> !core_stall);
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> (reg_rdata == '0));
endmodule

bind debug_halt_ctrl debug_halt_ctrl_chk #(.NUM_EXC(NUM_EXC), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_we        (reg_we),
  .wr_why        (wr_why),
  .mode_off      (mode_off),
  .exc_valid     (exc_valid),
  .ignore_exc    (ignore_exc),
  .core_stall    (core_stall),
  .hold_reset    (hold_reset),
  .sys_rst_pulse (sys_rst_pulse),
  .reg_err       (reg_err),
  .reg_rdata     (reg_rdata),
  .reason_q      (reason_q)
);

// File: tb/debug_halt_ctrl_test.sv
module debug_halt_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_code = '0;
  logic        ignore_exc, core_stall, hold_reset, sys_rst_pulse;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  debug_halt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .exc_valid(exc_valid), .exc_code(exc_code),
    .ignore_exc(ignore_exc), .core_stall(core_stall),
    .hold_reset(hold_reset), .sys_rst_pulse(sys_rst_pulse)
  );

  // {trap enable[12:0], code[3:0], trapped}
  localparam logic [17:0] VEC [8] = '{
    {13'h0001, 4'd0,  1'b1},
    {13'h0001, 4'd1,  1'b0},
    {13'h1000, 4'd12, 1'b1},
    {13'h1FFF, 4'd13, 1'b0},
    {13'h0040, 4'd6,  1'b1},
    {13'h1FBF, 4'd6,  1'b0},
    {13'h0100, 4'd8,  1'b1},
    {13'h1FFF, 4'd15, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_re = 1'b1; reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    reg_re = 1'b0;
  endtask

  task automatic exc(input logic [3:0] c);
    exc_valid = 1'b1; exc_code = c;
    tick();
    exc_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R4 reset stall", core_stall, 0);
    chk("R1 reset hold", hold_reset, 0);
    chk("R2 reset pulse", sys_rst_pulse, 0);
    rd(3'd0, 0, "R1 reset ctrl");
    rd(3'd3, 0, "R6 reset reason");

    // table walk: R5 R6 R7 R11
    foreach (VEC[i]) begin
      wr(3'd2, 32'(VEC[i][17:5]));
      wr(3'd3, 32'h1FFF);
      wr(3'd0, 32'h0);
      exc_valid = 1'b1; exc_code = VEC[i][4:1];
      #1;
      chk("R5/R11 ignore_exc", ignore_exc, VEC[i][0]);
      tick();
      exc_valid = 1'b0;
      chk("R7 stall after exception", core_stall, VEC[i][0]);
      rd(3'd3, VEC[i][0] ? (32'h1 << VEC[i][4:1]) : 0, "R6 reason after exception");
    end

    // R1 control write and readback
    wr(3'd0, 32'h1);
    chk("R1 stall set", core_stall, 1);
    rd(3'd0, 32'h1, "R1 ctrl readback");
    // R4 mode mask
    wr(3'd1, 32'h1);
    chk("R4 masked stall", core_stall, 0);
    rd(3'd0, 32'h1, "R4 stall bit kept");
    wr(3'd1, 32'h0);
    chk("R4 unmasked stall", core_stall, 1);
    // R7 disabled exception clears stall
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h1FFF);
    exc(4'd3);
    chk("R7 miss clears stall", core_stall, 0);
    rd(3'd3, 0, "R7 miss keeps reason");

    // R3 hold in reset suppresses
    wr(3'd2, 32'h1FFF);
    wr(3'd0, 32'h3);
    chk("R1 hold set", hold_reset, 1);
    exc_valid = 1'b1; exc_code = 4'd4;
    #1;
    chk("R3 no ignore in hold", ignore_exc, 0);
    tick();
    exc_valid = 1'b0;
    rd(3'd3, 0, "R3 reason untouched");
    chk("R3 stall untouched", core_stall, 1);
    // R2 release pulse
    wr(3'd0, 32'h0);
    chk("R2 pulse on release", sys_rst_pulse, 1);
    tick();
    chk("R2 pulse one cycle", sys_rst_pulse, 0);
    wr(3'd0, 32'h0);
    chk("R2 no pulse without hold", sys_rst_pulse, 0);

    // R6 sticky accumulation
    exc(4'd2);
    exc(4'd5);
    rd(3'd3, 32'h24, "R6 sticky OR");
    // R8 write-one clear, and set wins
    wr(3'd3, 32'h4);
    rd(3'd3, 32'h20, "R8 clear one bit");
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h20;
    exc_valid = 1'b1; exc_code = 4'd5;
    tick();
    reg_we = 1'b0; exc_valid = 1'b0;
    rd(3'd3, 32'h20, "R8 set wins over clear");

    // R10 write beats trap on stall
    wr(3'd3, 32'h1FFF);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0;
    exc_valid = 1'b1; exc_code = 4'd7;
    tick();
    reg_we = 1'b0; exc_valid = 1'b0;
    chk("R10 written stall wins", core_stall, 0);
    rd(3'd3, 32'h80, "R10 reason still set");

    // R9 unmapped
    rd(3'd5, 0, "R9 unmapped read zero");
    reg_re = 1'b1; reg_addr = 3'd5; #1;
    chk("R9 err flag", reg_err, 1);
    reg_re = 1'b0; reg_addr = 3'd2; #1;
    chk("R9 no err on mapped", reg_err, 0);
    wr(3'd6, 32'h0);
    wr(3'd4, 32'h3);
    rd(3'd2, 32'h1FFF, "R9 write ignored trap enable");
    rd(3'd0, 32'h0, "R9 write ignored ctrl");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule